// File: doc/BRIEF.md
# Power-State Clock Gating Window Controller

This block decides when the clocks of a bridge may be stopped during a low-power state. It watches system-management broadcasts that arrive from a link. Each broadcast has a kind and a 3-bit action code. A stop-grant broadcast opens a gating window when the bit that its action code selects is set in an enable mask. A broadcast that ends the clock-stop request closes the window again. Two independent domains each have their own mask and window. The internal domain gates the internal clock grids. The external domain stops the bridge clock output and the grids that go with it.

An open window only arms gating. The gate itself closes when the active-low link-stop pin is asserted while the window is open, and it opens again when the pin is released. The pin is asynchronous, so it passes through a two-flop synchronizer. If link-stop is already asserted when a window opens, gating waits until the pin has been seen released and then asserted again. Each window and each gate is reported on its own output.

Top module: `pwr_clkgate_ctrl`

## Requirements
- R1: Message kind stop-grant (msg_kind_i = 2'b01) with msg_valid_i high opens the internal window on the next rising edge when int_mask_i[msg_action_i] is 1. The internal window is unchanged when that bit is 0.
- R2: The external window follows the same rule using ext_mask_i, independently of the internal window.
- R3: Message kind stop-end (2'b10) with msg_valid_i high closes both windows on the next rising edge, whatever the action code and masks are, and both gates release in that same cycle.
- R4: A gate output is high only while its window is open and the synchronized link-stop is asserted.
- R5: With a window armed, a link-stop change made between two rising edges shows on the gate outputs just after the second rising edge that follows it. This holds for both assertion and release.
- R6: If link-stop is asserted when a window opens, that domain does not gate until link-stop has been seen deasserted and then asserted again.
- R7: Kinds 2'b00 and 2'b11, and any message with msg_valid_i low, change no window.
- R8: Synchronous reset closes both windows, clears both gates and drives bridge_clk_run_o high. The synchronizer resets to the released level.
- R9: bridge_clk_run_o is low exactly while the external gate is active. The internal gate never affects it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| msg_valid_i | input | 1 | Broadcast present this cycle |
| msg_kind_i | input | 2 | Broadcast kind: 01 stop-grant, 10 stop-end |
| msg_action_i | input | ACT_W | Action code of the broadcast |
| int_mask_i | input | 2**ACT_W | Enable mask of the internal domain |
| ext_mask_i | input | 2**ACT_W | Enable mask of the external domain |
| link_stop_n_i | input | 1 | Asynchronous link-stop, active low |
| int_win_o | output | 1 | Internal window open |
| ext_win_o | output | 1 | External window open |
| int_gate_o | output | 1 | Internal grids gated |
| ext_gate_o | output | 1 | External clock and grids gated |
| bridge_clk_run_o | output | 1 | Low forces the bridge clock output low |

## Verification
A window register stuck in the wrong state shows on its window output one cycle after the broadcast that should have changed it. The bench compares these outputs on every cycle, so such a fault is caught at once. A wrong arming state shows on a gate output two edges after link-stop next falls. The bench covers this by asserting link-stop both before and after a window opens. A synchronizer of the wrong depth moves each gate edge by one cycle, and the per-cycle comparison against the bench model reports that cycle.

// File: rtl/pcg_pkg.sv
package pcg_pkg;

    localparam int N_DOM   = 2;
    localparam int DOM_INT = 0;
    localparam int DOM_EXT = 1;

    typedef enum logic [1:0] {
        MK_IDLE       = 2'b00,
        MK_STOP_GRANT = 2'b01,
        MK_STOP_END   = 2'b10,
        MK_RSVD       = 2'b11
    } msg_kind_e;

    typedef struct packed {
        logic open_req;
        logic close_req;
    } win_cmd_t;

    typedef struct packed {
        logic win;
        logic gate;
    } dom_stat_t;

endpackage

// File: rtl/pcg_sync.sv
module pcg_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= {STAGES{RST_VAL}};
        else     chain_q <= {chain_q[STAGES-2:0], d_i};
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pcg_msg_decode.sv
module pcg_msg_decode
    import pcg_pkg::*;
#(
    parameter int ACT_W  = 3,
    localparam int MASK_W = 1 << ACT_W
) (
    input  logic                             valid_i,
    input  logic [1:0]                       kind_i,
    input  logic [ACT_W-1:0]                 action_i,
    input  logic [N_DOM-1:0][MASK_W-1:0]     masks_i,
    output win_cmd_t [N_DOM-1:0]             cmd_o
);
    msg_kind_e kind;
    assign kind = msg_kind_e'(kind_i);

    for (genvar d = 0; d < N_DOM; d++) begin : g_dom
        always_comb begin
            cmd_o[d].open_req  = valid_i && (kind == MK_STOP_GRANT) && masks_i[d][action_i];
            cmd_o[d].close_req = valid_i && (kind == MK_STOP_END);
        end
    end
endmodule

// File: rtl/pcg_window.sv
module pcg_window
    import pcg_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  win_cmd_t  cmd_i,
    input  logic      stop_i,
    output dom_stat_t stat_o
);
    logic win_q, win_d;
    logic armed_q, armed_d;

    always_comb begin
        win_d = win_q;
        if (cmd_i.close_req)     win_d = 1'b0;
        else if (cmd_i.open_req) win_d = 1'b1;
        armed_d = win_d && (armed_q || !stop_i);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            win_q   <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            win_q   <= win_d;
            armed_q <= armed_d;
        end
    end

    assign stat_o.win  = win_q;
    assign stat_o.gate = armed_q && stop_i;

    // R1 (and R2 for the external instance)
    assert_open_R1: assert property (@(posedge clk) disable iff (rst)
        (cmd_i.open_req && !cmd_i.close_req) |=> stat_o.win);
    assert_close_R3: assert property (@(posedge clk) disable iff (rst)
        cmd_i.close_req |=> (!stat_o.win && !stat_o.gate));
    assert_gate_win_R4: assert property (@(posedge clk) disable iff (rst)
        stat_o.gate |-> (stat_o.win && stop_i));
    assert_no_early_gate_R6: assert property (@(posedge clk) disable iff (rst)
        ($rose(stat_o.win) && $past(stop_i)) |-> !stat_o.gate);
    assert_reset_R8: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!stat_o.win && !stat_o.gate));
endmodule

// File: rtl/pwr_clkgate_ctrl.sv
module pwr_clkgate_ctrl
    import pcg_pkg::*;
#(
    parameter int ACT_W       = 3,
    parameter int SYNC_STAGES = 2,
    localparam int MASK_W     = 1 << ACT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              msg_valid_i,
    input  logic [1:0]        msg_kind_i,
    input  logic [ACT_W-1:0]  msg_action_i,
    input  logic [MASK_W-1:0] int_mask_i,
    input  logic [MASK_W-1:0] ext_mask_i,
    input  logic              link_stop_n_i,
    output logic              int_win_o,
    output logic              ext_win_o,
    output logic              int_gate_o,
    output logic              ext_gate_o,
    output logic              bridge_clk_run_o
);
    logic                         stop_n_s;
    logic                         stop_s;
    logic [N_DOM-1:0][MASK_W-1:0] masks;
    win_cmd_t [N_DOM-1:0]         cmds;
    dom_stat_t [N_DOM-1:0]        stats;

    pcg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (link_stop_n_i),
        .q_o (stop_n_s)
    );
    assign stop_s = !stop_n_s;

    assign masks[DOM_INT] = int_mask_i;
    assign masks[DOM_EXT] = ext_mask_i;

    pcg_msg_decode #(.ACT_W(ACT_W)) u_dec (
        .valid_i  (msg_valid_i),
        .kind_i   (msg_kind_i),
        .action_i (msg_action_i),
        .masks_i  (masks),
        .cmd_o    (cmds)
    );

    for (genvar d = 0; d < N_DOM; d++) begin : g_win
        pcg_window u_win (
            .clk    (clk),
            .rst    (rst),
            .cmd_i  (cmds[d]),
            .stop_i (stop_s),
            .stat_o (stats[d])
        );
    end

    assign int_win_o        = stats[DOM_INT].win;
    assign ext_win_o        = stats[DOM_EXT].win;
    assign int_gate_o       = stats[DOM_INT].gate;
    assign ext_gate_o       = stats[DOM_EXT].gate;
    assign bridge_clk_run_o = !stats[DOM_EXT].gate;

    assert_release_R5: assert property (@(posedge clk) disable iff (rst)
        !stop_s |-> (!int_gate_o && !ext_gate_o));
    assert_clk_run_R9: assert property (@(posedge clk) disable iff (rst)
        (int_gate_o && !ext_win_o) |-> bridge_clk_run_o);
endmodule

// File: tb/tb_pwr_clkgate_ctrl.sv
module tb_pwr_clkgate_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       msg_valid_i = 1'b0;
    logic [1:0] msg_kind_i = 2'b00;
    logic [2:0] msg_action_i = 3'd0;
    logic [7:0] int_mask_i = 8'h00;
    logic [7:0] ext_mask_i = 8'h00;
    logic       link_stop_n_i = 1'b1;
    logic int_win_o, ext_win_o, int_gate_o, ext_gate_o, bridge_clk_run_o;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 0;

    always #10 clk = ~clk;

    pwr_clkgate_ctrl dut (
        .clk(clk), .rst(rst), .msg_valid_i(msg_valid_i), .msg_kind_i(msg_kind_i),
        .msg_action_i(msg_action_i), .int_mask_i(int_mask_i), .ext_mask_i(ext_mask_i),
        .link_stop_n_i(link_stop_n_i), .int_win_o(int_win_o), .ext_win_o(ext_win_o),
        .int_gate_o(int_gate_o), .ext_gate_o(ext_gate_o), .bridge_clk_run_o(bridge_clk_run_o)
    );

    // Behavioural reference: pin history queue, window and arming flags per domain
    bit m_win[2];
    bit m_arm[2];
    bit hist[$];
    bit m_stop_old;
    bit m_open, m_close, m_nw;

    initial hist = '{1'b1, 1'b1};

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_win = '{1'b0, 1'b0};
            m_arm = '{1'b0, 1'b0};
            hist = '{1'b1, 1'b1};
        end else begin
            m_stop_old = (hist[0] == 1'b0);
            for (int d = 0; d < 2; d++) begin
                m_open  = msg_valid_i && msg_kind_i == 2'b01 &&
                          (d == 0 ? int_mask_i[msg_action_i] : ext_mask_i[msg_action_i]);
                m_close = msg_valid_i && msg_kind_i == 2'b10;
                m_nw = m_close ? 1'b0 : (m_open ? 1'b1 : m_win[d]);
                m_arm[d] = m_nw && (m_arm[d] || !m_stop_old);
                m_win[d] = m_nw;
            end
            hist.push_back(link_stop_n_i);
            void'(hist.pop_front());
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at cycle %0d: actual %b expected %b", tag, cyc, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R1 int window model", int_win_o, m_win[0]);
            chk("R2 ext window model", ext_win_o, m_win[1]);
            chk("R4 int gate model", int_gate_o, m_arm[0] && hist[0] == 1'b0);
            chk("R5 ext gate model", ext_gate_o, m_arm[1] && hist[0] == 1'b0);
            chk("R9 clk run model", bridge_clk_run_o, !(m_arm[1] && hist[0] == 1'b0));
        end
    end

    task automatic finish_run();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        while (cyc < 200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    task automatic send(input logic v, input logic [1:0] k, input logic [2:0] a);
        msg_valid_i = v; msg_kind_i = k; msg_action_i = a;
        @(negedge clk);
        msg_valid_i = 1'b0; msg_kind_i = 2'b00; msg_action_i = 3'd0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        @(negedge clk); @(negedge clk); @(negedge clk);
        rst = 1'b0;
        chk("R8 reset int win", int_win_o, 1'b0);
        chk("R8 reset ext win", ext_win_o, 1'b0);
        chk("R8 reset int gate", int_gate_o, 1'b0);
        chk("R8 reset clk run", bridge_clk_run_o, 1'b1);

        int_mask_i = 8'h24;   // bits 2,5
        ext_mask_i = 8'h81;   // bits 0,7
        send(1'b1, 2'b01, 3'd3);
        chk("R1 unmasked code keeps int closed", int_win_o, 1'b0);
        chk("R2 unmasked code keeps ext closed", ext_win_o, 1'b0);
        send(1'b1, 2'b01, 3'd5);
        chk("R1 int opens", int_win_o, 1'b1);
        chk("R2 ext independent", ext_win_o, 1'b0);

        link_stop_n_i = 1'b0;
        idle(1);
        chk("R5 int gate not yet after one edge", int_gate_o, 1'b0);
        idle(1);
        chk("R5 int gate after two edges", int_gate_o, 1'b1);
        chk("R9 int gate leaves clk run", bridge_clk_run_o, 1'b1);
        link_stop_n_i = 1'b1;
        idle(1);
        chk("R5 int still gated after one edge", int_gate_o, 1'b1);
        idle(1);
        chk("R5 int released after two edges", int_gate_o, 1'b0);

        send(1'b1, 2'b01, 3'd7);
        chk("R2 ext opens", ext_win_o, 1'b1);
        link_stop_n_i = 1'b0;
        idle(2);
        chk("R5 ext gated", ext_gate_o, 1'b1);
        chk("R9 clk run low", bridge_clk_run_o, 1'b0);
        chk("R4 both gated", int_gate_o, 1'b1);

        send(1'b1, 2'b11, 3'd0);
        chk("R7 reserved kind ignored", ext_win_o, 1'b1);
        send(1'b0, 2'b10, 3'd0);
        chk("R7 invalid close ignored", int_win_o, 1'b1);
        chk("R7 gate kept", ext_gate_o, 1'b1);

        send(1'b1, 2'b10, 3'd4);
        chk("R3 int closed", int_win_o, 1'b0);
        chk("R3 ext closed", ext_win_o, 1'b0);
        chk("R3 gate released", ext_gate_o, 1'b0);
        chk("R3 clk run back", bridge_clk_run_o, 1'b1);
        chk("R4 no gate without window", int_gate_o, 1'b0);

        // link-stop still asserted: open ext window
        send(1'b1, 2'b01, 3'd0);
        chk("R6 ext open", ext_win_o, 1'b1);
        idle(3);
        chk("R6 no gate while stop held", ext_gate_o, 1'b0);
        link_stop_n_i = 1'b1;
        idle(3);
        link_stop_n_i = 1'b0;
        idle(2);
        chk("R6 gate after re-assert", ext_gate_o, 1'b1);
        link_stop_n_i = 1'b1;
        idle(2);
        chk("R5 ext released", bridge_clk_run_o, 1'b1);

        rst = 1'b1; idle(1); rst = 1'b0;
        chk("R8 mid-run reset closes", ext_win_o, 1'b0);

        for (int i = 0; i < 3000; i++) begin
            if ($urandom_range(0, 5) == 0) link_stop_n_i = ~link_stop_n_i;
            if ($urandom_range(0, 3) == 0) begin
                int_mask_i = 8'($urandom);
                ext_mask_i = 8'($urandom);
                send(1'($urandom), 2'($urandom), 3'($urandom));
            end else idle(1);
        end
        link_stop_n_i = 1'b1;
        idle(3);
        finish_run();
    end
endmodule